// File: doc/BRIEF.md
# Colour Lookup Table Load and Readback Port

This block holds the colour lookup table of a display pipeline and gives a host a narrow 32-bit register window to fill it. The table has 256 pseudocolour entries for ordinary pixels and 4 more entries that the cursor overlay uses. Each entry stores an 8-bit red, green and blue value. The host first writes an entry number. It then moves one colour byte per access through a data port, always in the order red, green, blue. A small phase counter tracks which component comes next. After the blue access the entry number steps forward by one, so a whole table can be streamed without rewriting the entry number.

Reads through a data port return the stored components in the same order and move the phase counter in the same way, so writes and reads share one sequence. A second, independent port lets the pixel pipeline look up any of the 260 entries and receive its 24-bit colour one clock later. Accesses to other offsets are accepted and have no effect.

Top module: `clut_port`

## Requirements
- R1: After reset every entry is zero, except entries 255, 256 and 258, which hold 0xFFFFFF. The entry number and the phase start at 0 and red.
- R2: A write at byte offset 0 loads the entry number from bits 31:24 of the write data and sets the phase to red.
- R3: A write at offset 4 stores bits 31:24 of the write data into the component of the current entry chosen by the phase: red, then green, then blue.
- R4: After each blue access at a data port, the entry number increments modulo 256, so 255 wraps to 0, and the phase returns to red.
- R5: Offset 12 is the overlay data port. It addresses entry 256 plus bits 1:0 of the entry number, and it steps the phase and the full 8-bit entry number in the same way as offset 4.
- R6: A read at offset 4 or 12 returns the current component of the addressed entry on bits 31:24 of the read data in the next cycle. Bits 23:0 are zero, and the read advances the phase like a write.
- R7: A write at offset 8, or at any offset other than 0, 4 and 12, changes no entry, entry number or phase. A read at any offset other than 4 and 12 returns zero in the next cycle and does not advance the phase.
- R8: The lookup port returns the entry chosen by its 9-bit entry number one cycle later, packed as red in 23:16, green in 15:8 and blue in 7:0. A same-cycle write is not yet visible, and entry numbers 260 to 511 return zero.
- R9: Reads and writes at the data ports share one phase, so they may be interleaved within one red, green, blue sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | One register access this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 4 | Byte offset of the access, word aligned |
| bus_wdata | input | 32 | Write data; colour byte and entry number in 31:24 |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read |
| lut_idx | input | 9 | Entry number for the pixel lookup |
| lut_rgb | output | 24 | Looked-up colour, one cycle after lut_idx |

## Verification
The assertions assume that the host issues at most one access per cycle with a word-aligned offset, so bits 1:0 of bus_addr are zero. They also assume that the phase can only be reached through the sequencer, which keeps it inside its three legal values. The stimulus only ever drives offsets 0, 4, 8 and 12. It mixes directed sequences with seeded pseudo-random traffic over those offsets, while the lookup index sweeps freely over all 512 values, including the unused range above 259.

// File: rtl/clut_port.sv
module clut_port #(
  parameter int BASE_ENTRIES = 256,
  parameter int OVL_ENTRIES  = 4,
  parameter int CW           = 8
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       bus_sel,
  input  logic                                       bus_wr,
  input  logic [3:0]                                 bus_addr,
  input  logic [31:0]                                bus_wdata,
  output logic [31:0]                                bus_rdata,
  input  logic [$clog2(BASE_ENTRIES+OVL_ENTRIES)-1:0] lut_idx,
  output logic [3*CW-1:0]                            lut_rgb
);
  localparam int IW    = $clog2(BASE_ENTRIES);
  localparam int OW    = $clog2(OVL_ENTRIES);
  localparam int TOTAL = BASE_ENTRIES + OVL_ENTRIES;
  localparam int EW    = $clog2(TOTAL);
  localparam int RGBW  = 3 * CW;

  localparam logic [1:0] PH_R = 2'd0;
  localparam logic [1:0] PH_G = 2'd1;
  localparam logic [1:0] PH_B = 2'd2;

  logic [RGBW-1:0] pal [TOTAL];
  logic [IW-1:0]   idx;
  logic [1:0]      phase;
  logic [EW-1:0]   tgt;
  logic [CW-1:0]   comp;
  logic [CW-1:0]   wbyte;
  logic            unused_low;

  wire hit_idx  = bus_sel && (bus_addr == 4'd0);
  wire hit_pix  = bus_sel && (bus_addr == 4'd4);
  wire hit_ovl  = bus_sel && (bus_addr == 4'd12);
  wire data_hit = hit_pix || hit_ovl;

  assign wbyte      = bus_wdata[31 -: CW];
  assign unused_low = ^bus_wdata[31-CW:0];
  assign tgt = hit_ovl ? EW'(BASE_ENTRIES) + EW'(idx[OW-1:0]) : EW'(idx);

  always_comb begin
    case (phase)
      PH_R:    comp = pal[tgt][3*CW-1:2*CW];
      PH_G:    comp = pal[tgt][2*CW-1:CW];
      default: comp = pal[tgt][CW-1:0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TOTAL; i++)
        pal[i] <= (i == BASE_ENTRIES-1 || i == BASE_ENTRIES || i == BASE_ENTRIES+2) ? '1 : '0;
    end else if (data_hit && bus_wr) begin
      case (phase)
        PH_R:    pal[tgt][3*CW-1:2*CW] <= wbyte;
        PH_G:    pal[tgt][2*CW-1:CW]   <= wbyte;
        default: pal[tgt][CW-1:0]      <= wbyte;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= '0;
      phase <= PH_R;
    end else if (hit_idx && bus_wr) begin
      idx   <= bus_wdata[31 -: IW];
      phase <= PH_R;
    end else if (data_hit) begin
      if (phase == PH_B) begin
        phase <= PH_R;
        idx   <= idx + 1'b1;
      end else begin
        phase <= phase + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      lut_rgb   <= '0;
    end else begin
      bus_rdata <= (data_hit && !bus_wr) ? {comp, {(32-CW){1'b0}}} : '0;
      lut_rgb   <= (lut_idx < EW'(TOTAL)) ? pal[lut_idx] : '0;
    end
  end

  a_r4_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3);

  a_r2_index_load: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_idx && bus_wr) |=> (phase == PH_R) && (idx == $past(bus_wdata[31 -: IW])));

  a_r4_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    (data_hit && phase == PH_B) |=> (phase == PH_R) && (idx == $past(idx) + 1'b1));

  a_r6_rdata_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[31-CW:0] == '0);

  a_r7_other_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !hit_idx && !data_hit) |=> $stable(idx) && $stable(phase) && (bus_rdata == '0));

  a_r8_range_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (lut_idx >= EW'(TOTAL)) |=> (lut_rgb == '0));
endmodule

// File: tb/tb_clut_port.sv
module tb_clut_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [8:0]  lut_idx = '0;
  logic [23:0] lut_rgb;

  always #5 clk = ~clk;

  clut_port dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lut_idx(lut_idx), .lut_rgb(lut_rgb)
  );

  int checks = 0;
  int errors = 0;
  int mr [0:259];
  int mg [0:259];
  int mb [0:259];
  int m_idx, m_ph, t, byteval;
  logic [31:0] exp_rd;
  logic [23:0] exp_lut;
  string cur_req = "R1";
  string exp_tag = "R1";
  bit armed = 1'b0;
  bit done = 1'b0;

  // Behavioural reference model, updated on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 260; i++) begin
        mr[i] = 0; mg[i] = 0; mb[i] = 0;
      end
      mr[255] = 255; mg[255] = 255; mb[255] = 255;
      mr[256] = 255; mg[256] = 255; mb[256] = 255;
      mr[258] = 255; mg[258] = 255; mb[258] = 255;
      m_idx = 0; m_ph = 0; exp_rd = '0; exp_lut = '0;
    end else begin
      if (lut_idx < 260)
        exp_lut = {mr[lut_idx][7:0], mg[lut_idx][7:0], mb[lut_idx][7:0]};
      else
        exp_lut = '0;
      exp_rd = '0;
      if (bus_sel) begin
        if (bus_wr && bus_addr == 4'd0) begin
          m_idx = bus_wdata[31:24];
          m_ph  = 0;
        end else if (bus_addr == 4'd4 || bus_addr == 4'd12) begin
          t = (bus_addr == 4'd12) ? 256 + (m_idx % 4) : m_idx;
          if (bus_wr) begin
            byteval = bus_wdata[31:24];
            if (m_ph == 0) mr[t] = byteval;
            else if (m_ph == 1) mg[t] = byteval;
            else mb[t] = byteval;
          end else begin
            if (m_ph == 0) byteval = mr[t];
            else if (m_ph == 1) byteval = mg[t];
            else byteval = mb[t];
            exp_rd = {byteval[7:0], 24'h0};
          end
          if (m_ph == 2) begin
            m_ph = 0;
            m_idx = (m_idx + 1) % 256;
          end else begin
            m_ph = m_ph + 1;
          end
        end
      end
    end
    exp_tag = cur_req;
    armed = 1'b1;
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (armed && !done) begin
      checks++;
      if (bus_rdata !== exp_rd) begin
        errors++;
        $display("FAIL %s read data: actual %h expected %h", exp_tag, bus_rdata, exp_rd);
      end
      checks++;
      if (lut_rgb !== exp_lut) begin
        errors++;
        $display("FAIL %s lookup: actual %h expected %h", exp_tag, lut_rgb, exp_lut);
      end
    end
  end

  task automatic cyc(input bit s, input bit w, input logic [3:0] a,
                     input logic [7:0] b, input logic [8:0] li);
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = {b, 24'h5A5A5A}; lut_idx = li;
    @(negedge clk);
  endtask

  task automatic idle(input logic [8:0] li);
    cyc(1'b0, 1'b0, 4'd0, 8'd0, li);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    for (int i = 0; i < 260; i++) idle(9'(i));
    cur_req = "R8";
    idle(9'd260); idle(9'd300); idle(9'd511);

    cur_req = "R2";
    cyc(1, 1, 4'd0, 8'd5, 9'd5);
    cur_req = "R3";
    cyc(1, 1, 4'd4, 8'h11, 9'd5);
    cyc(1, 1, 4'd4, 8'h22, 9'd5);
    cyc(1, 1, 4'd4, 8'h33, 9'd5);
    cyc(1, 1, 4'd4, 8'h44, 9'd5);
    idle(9'd5); idle(9'd6);
    cur_req = "R2";
    cyc(1, 1, 4'd0, 8'd5, 9'd6);
    cur_req = "R6";
    cyc(1, 0, 4'd4, 8'd0, 9'd6);
    cyc(1, 0, 4'd4, 8'd0, 9'd6);
    cyc(1, 0, 4'd4, 8'd0, 9'd6);
    cyc(1, 0, 4'd4, 8'd0, 9'd6);
    idle(9'd0);

    cur_req = "R4";
    cyc(1, 1, 4'd0, 8'd255, 9'd255);
    cyc(1, 1, 4'd4, 8'h01, 9'd255);
    cyc(1, 1, 4'd4, 8'h02, 9'd255);
    cyc(1, 1, 4'd4, 8'h03, 9'd255);
    cyc(1, 1, 4'd4, 8'h0A, 9'd0);
    cyc(1, 1, 4'd4, 8'h0B, 9'd0);
    cyc(1, 1, 4'd4, 8'h0C, 9'd0);
    idle(9'd255); idle(9'd0);

    cur_req = "R5";
    cyc(1, 1, 4'd0, 8'h0A, 9'd258);
    cyc(1, 1, 4'd12, 8'h81, 9'd258);
    cyc(1, 1, 4'd12, 8'h82, 9'd258);
    cyc(1, 1, 4'd12, 8'h83, 9'd258);
    cyc(1, 1, 4'd12, 8'h91, 9'd259);
    cyc(1, 1, 4'd12, 8'h92, 9'd259);
    cyc(1, 1, 4'd12, 8'h93, 9'd259);
    idle(9'd258); idle(9'd259); idle(9'd10); idle(9'd11);
    cyc(1, 1, 4'd0, 8'h0A, 9'd10);
    cyc(1, 0, 4'd12, 8'd0, 9'd258);
    cyc(1, 0, 4'd12, 8'd0, 9'd258);
    cyc(1, 0, 4'd12, 8'd0, 9'd258);
    idle(9'd0);

    cur_req = "R7";
    cyc(1, 1, 4'd0, 8'd20, 9'd20);
    cyc(1, 1, 4'd4, 8'hA1, 9'd20);
    cyc(1, 1, 4'd8, 8'hEE, 9'd20);
    cyc(1, 0, 4'd8, 8'd0, 9'd20);
    cyc(1, 0, 4'd0, 8'd0, 9'd20);
    cyc(1, 1, 4'd4, 8'hA2, 9'd20);
    cyc(1, 1, 4'd4, 8'hA3, 9'd20);
    idle(9'd20); idle(9'd21);

    cur_req = "R9";
    cyc(1, 1, 4'd0, 8'd30, 9'd30);
    cyc(1, 1, 4'd4, 8'hC1, 9'd30);
    cyc(1, 0, 4'd4, 8'd0, 9'd30);
    cyc(1, 1, 4'd4, 8'hC3, 9'd30);
    cyc(1, 0, 4'd4, 8'd0, 9'd31);
    idle(9'd30); idle(9'd31);

    cur_req = "R3";
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] rv;
      logic [3:0] a;
      rv = $urandom;
      a = {rv[1:0], 2'b00};
      cyc(rv[2], rv[3], a, rv[15:8], rv[24:16]);
    end
    idle(9'd0); idle(9'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    done = 1'b1;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule